// File: doc/BRIEF.md
# Four-Window Bank Mapper

This block lets a CPU with a 16-bit address reach more ROM and RAM than 64 KB allows. Address bits 15:14 split the CPU space into four equal 16 KB windows, each with its own job. Window 0 (0000h–3FFFh) always shows ROM page 0. Window 1 (4000h–7FFFh) shows the ROM page held in a software-loaded ROM page register. Window 2 (8000h–BFFFh) shows the RAM page held in a RAM page register. Window 3 (C000h–FFFFh) always shows RAM page 0. The low 14 address bits are the offset inside the page. The block puts the page number in front of that offset to form the physical address.

Software loads a page register through a small write port: a strobe, a select bit and a 4-bit value. Each register accepts only values in its legal range (ROM 1 to 15, RAM 1 to 7). Any other value is dropped. All outputs are registered, so the chip selects and physical addresses for an access appear one clock after the access is presented. Writes aimed at either ROM window are suppressed.

Top module: `bank_mapper`

## Requirements
- R1: Synchronous reset clears rom_cs, ram_cs and ram_we. It also sets both page registers to page 1, so the first window-1 read goes to ROM page 1 and the first window-2 access goes to RAM page 1.
- R2: A read with address bits 15:14 = 00 raises rom_cs, with rom_addr = {4'h0, addr[13:0]}.
- R3: A read with address bits 15:14 = 01 raises rom_cs, with rom_addr = {ROM page register, addr[13:0]}. Every page from 1 to 15 is reachable.
- R4: An access (read or write) with address bits 15:14 = 10 raises ram_cs, with ram_addr = {RAM page register, addr[13:0]}. ram_we is high exactly when the access is a write.
- R5: An access with address bits 15:14 = 11 raises ram_cs, with ram_addr = {3'h0, addr[13:0]}. ram_we is high exactly when the access is a write.
- R6: A write with address bit 15 = 0 (either ROM window) raises none of rom_cs, ram_cs or ram_we.
- R7: With pg_wr high, pg_sel = 0 loads the ROM page register and pg_sel = 1 loads the RAM page register. The other register is left unchanged. An access presented in the same cycle as the page write still uses the old page. Accesses presented after the capturing edge use the new page.
- R8: A ROM page write with value 0 is ignored. The ROM page register keeps its value.
- R9: A RAM page write with value 0 or 8 to 15 is ignored. The RAM page register keeps its value.
- R10: The outputs for an access appear one clock after it is presented. With neither rd nor wr high, rom_cs and ram_cs stay low. rom_cs and ram_cs are never high together.
- R11: When rd and wr are both high, the access is treated as a write. It raises ram_cs and ram_we in a RAM window and no select in a ROM window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| pg_wr | input | 1 | Page register write strobe |
| pg_sel | input | 1 | Target register: 0 = ROM page, 1 = RAM page |
| pg_data | input | 4 | New page value |
| rom_cs | output | 1 | ROM chip select (registered) |
| ram_cs | output | 1 | RAM chip select (registered) |
| ram_we | output | 1 | RAM write enable (registered) |
| rom_addr | output | 18 | Physical ROM address (registered) |
| ram_addr | output | 17 | Physical RAM address (registered) |

## Verification
The bench targets the following corner cases:
- **Page write in the same cycle as an access.** A mapper that forwards the incoming page value would send that access to the new page.
- **Illegal page values (ROM 0, RAM 0 and 8).** A mapper that loads them unchecked would send the next access into page 0, or wrap a RAM page, and the bench would see the wrong high address bits.
- **Writes into both ROM windows, including rd and wr together.** A design that forgot the suppression would raise a select or write enable there.
- **Register routing and boundaries.** The bench loads the RAM register and confirms the ROM page did not move. It also checks the top ROM page (15), the window edge addresses, and a reset in the middle of the run that must restore page 1.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  // Window index is address bits [top:top-1]; the order is the decode itself.
  typedef enum logic [1:0] {
    WIN_ROM_FIXED = 2'b00,
    WIN_ROM_SWAP  = 2'b01,
    WIN_RAM_SWAP  = 2'b10,
    WIN_RAM_FIXED = 2'b11
  } window_e;

  typedef struct packed {
    logic rom_sel;
    logic ram_sel;
    logic ram_wen;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{rom_sel: 1'b0, ram_sel: 1'b0, ram_wen: 1'b0};

endpackage

// File: rtl/bank_page_reg.sv
module bank_page_reg #(
  parameter int IN_W   = 4,
  parameter int PG_W   = 4,
  parameter int LO_PG  = 1,
  parameter int HI_PG  = 15,
  parameter int RST_PG = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IN_W-1:0] din,
  output logic [PG_W-1:0] page
);

  logic in_range;

  // Only values inside [LO_PG, HI_PG] are accepted; others leave page alone.
  assign in_range = (din >= IN_W'(LO_PG)) && (din <= IN_W'(HI_PG));

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= PG_W'(RST_PG);
    end else if (wr_en && in_range) begin
      page <= din[PG_W-1:0];
    end
  end

endmodule

// File: rtl/bank_window_decode.sv
module bank_window_decode
  import bank_mapper_pkg::*;
#(
  parameter int OFS_W    = 14,
  parameter int ROM_PG_W = 4,
  parameter int RAM_PG_W = 3
) (
  input  logic [OFS_W+1:0]        addr,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [ROM_PG_W-1:0]     rom_page,
  input  logic [RAM_PG_W-1:0]     ram_page,
  output strobe_t                 strb,
  output logic [ROM_PG_W+OFS_W-1:0] rom_phys,
  output logic [RAM_PG_W+OFS_W-1:0] ram_phys
);

  localparam int ADDR_W = OFS_W + 2;

  window_e               win;
  logic [ROM_PG_W-1:0]   rom_pg;
  logic [RAM_PG_W-1:0]   ram_pg;
  logic                  in_rom;
  logic [OFS_W-1:0]      offset;

  assign win    = window_e'(addr[ADDR_W-1:ADDR_W-2]);
  assign offset = addr[OFS_W-1:0];

  always_comb begin
    rom_pg = '0;
    ram_pg = '0;
    in_rom = 1'b1;
    case (win)
      WIN_ROM_FIXED: begin rom_pg = '0;       in_rom = 1'b1; end
      WIN_ROM_SWAP:  begin rom_pg = rom_page; in_rom = 1'b1; end
      WIN_RAM_SWAP:  begin ram_pg = ram_page; in_rom = 1'b0; end
      WIN_RAM_FIXED: begin ram_pg = '0;       in_rom = 1'b0; end
      default:       begin rom_pg = '0;       in_rom = 1'b1; end
    endcase
  end

  assign rom_phys = {rom_pg, offset};
  assign ram_phys = {ram_pg, offset};

  // A write (even with rd) wins; ROM is read-only so writes there select nothing.
  always_comb begin
    strb         = STROBE_IDLE;
    strb.rom_sel = in_rom & rd & ~wr;
    strb.ram_sel = ~in_rom & (rd | wr);
    strb.ram_wen = ~in_rom & wr;
  end

endmodule

// File: rtl/bank_out_reg.sv
module bank_out_reg
  import bank_mapper_pkg::*;
#(
  parameter int ROM_AW = 18,
  parameter int RAM_AW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb_d,
  input  logic [ROM_AW-1:0] rom_d,
  input  logic [RAM_AW-1:0] ram_d,
  output strobe_t           strb_q,
  output logic [ROM_AW-1:0] rom_q,
  output logic [RAM_AW-1:0] ram_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= STROBE_IDLE;
      rom_q  <= '0;
      ram_q  <= '0;
    end else begin
      strb_q <= strb_d;
      rom_q  <= rom_d;
      ram_q  <= ram_d;
    end
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int OFS_W    = 14,
  parameter int ROM_PG_W = 4,
  parameter int RAM_PG_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [OFS_W+1:0]          cpu_addr,
  input  logic                      cpu_rd,
  input  logic                      cpu_wr,
  input  logic                      pg_wr,
  input  logic                      pg_sel,
  input  logic [ROM_PG_W-1:0]       pg_data,
  output logic                      rom_cs,
  output logic                      ram_cs,
  output logic                      ram_we,
  output logic [ROM_PG_W+OFS_W-1:0] rom_addr,
  output logic [RAM_PG_W+OFS_W-1:0] ram_addr
);

  localparam int ROM_AW     = ROM_PG_W + OFS_W;
  localparam int RAM_AW     = RAM_PG_W + OFS_W;
  localparam int ROM_PG_MAX = (1 << ROM_PG_W) - 1;
  localparam int RAM_PG_MAX = (1 << RAM_PG_W) - 1;

  logic [ROM_PG_W-1:0] rom_page_q;
  logic [RAM_PG_W-1:0] ram_page_q;
  strobe_t             strb_d, strb_q;
  logic [ROM_AW-1:0]   rom_d;
  logic [RAM_AW-1:0]   ram_d;

  bank_page_reg #(
    .IN_W(ROM_PG_W), .PG_W(ROM_PG_W), .LO_PG(1), .HI_PG(ROM_PG_MAX), .RST_PG(1)
  ) u_rom_page (
    .clk(clk), .rst(rst), .wr_en(pg_wr & ~pg_sel), .din(pg_data), .page(rom_page_q)
  );

  bank_page_reg #(
    .IN_W(ROM_PG_W), .PG_W(RAM_PG_W), .LO_PG(1), .HI_PG(RAM_PG_MAX), .RST_PG(1)
  ) u_ram_page (
    .clk(clk), .rst(rst), .wr_en(pg_wr & pg_sel), .din(pg_data), .page(ram_page_q)
  );

  bank_window_decode #(
    .OFS_W(OFS_W), .ROM_PG_W(ROM_PG_W), .RAM_PG_W(RAM_PG_W)
  ) u_decode (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .rom_page(rom_page_q), .ram_page(ram_page_q),
    .strb(strb_d), .rom_phys(rom_d), .ram_phys(ram_d)
  );

  bank_out_reg #(
    .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
  ) u_out (
    .clk(clk), .rst(rst), .strb_d(strb_d), .rom_d(rom_d), .ram_d(ram_d),
    .strb_q(strb_q), .rom_q(rom_addr), .ram_q(ram_addr)
  );

  assign rom_cs = strb_q.rom_sel;
  assign ram_cs = strb_q.ram_sel;
  assign ram_we = strb_q.ram_wen;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int OFS_W    = 14,
  parameter int ROM_PG_W = 4,
  parameter int RAM_PG_W = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [OFS_W+1:0]          cpu_addr,
  input logic                      cpu_rd,
  input logic                      cpu_wr,
  input logic                      rom_cs,
  input logic                      ram_cs,
  input logic                      ram_we,
  input logic [ROM_PG_W+OFS_W-1:0] rom_addr,
  input logic [RAM_PG_W+OFS_W-1:0] ram_addr,
  input logic [ROM_PG_W-1:0]       rom_page_q,
  input logic [RAM_PG_W-1:0]       ram_page_q
);

  localparam int TOP = OFS_W + 1;

  // R10
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rom_cs && ram_cs));

  // R10
  idle_no_select_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> (!rom_cs && !ram_cs && !ram_we));

  // R4
  wen_needs_ram_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_cs);

  // R6
  rom_write_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[TOP]) |=> (!rom_cs && !ram_cs && !ram_we));

  // R2
  rom_fixed_page_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !cpu_wr && cpu_addr[TOP:TOP-1] == 2'b00)
      |=> (rom_cs && rom_addr[ROM_PG_W+OFS_W-1:OFS_W] == '0
           && rom_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])));

  // R5
  ram_fixed_page_chk: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || cpu_wr) && cpu_addr[TOP:TOP-1] == 2'b11)
      |=> (ram_cs && ram_addr[RAM_PG_W+OFS_W-1:OFS_W] == '0
           && ram_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])));

  // R8
  rom_page_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rom_page_q != '0);

  // R9
  ram_page_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ram_page_q != '0);

endmodule

bind bank_mapper bank_mapper_chk #(
  .OFS_W(OFS_W), .ROM_PG_W(ROM_PG_W), .RAM_PG_W(RAM_PG_W)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we),
  .rom_addr(rom_addr), .ram_addr(ram_addr),
  .rom_page_q(rom_page_q), .ram_page_q(ram_page_q)
);

// File: tb/test_bank_mapper.sv
module test_bank_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic        pg_wr = 1'b0, pg_sel = 1'b0;
  logic [3:0]  pg_data = '0;
  logic        rom_cs, ram_cs, ram_we;
  logic [17:0] rom_addr;
  logic [16:0] ram_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  bank_mapper i_bank_mapper (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .pg_wr(pg_wr), .pg_sel(pg_sel), .pg_data(pg_data),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we),
    .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  typedef struct packed {
    logic       pw;
    logic       ps;
    logic [3:0] pd;
    logic [15:0] a;
    logic       rd;
    logic       wr;
    logic       x_rom;
    logic       x_ram;
    logic       x_we;
    logic [3:0] x_rpg;
    logic [2:0] x_mpg;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,4'h0,16'h1234,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'h0,3'h0, 8'd2},  // R2
    '{1'b0,1'b0,4'h0,16'h4ABC,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'h1,3'h0, 8'd1},  // R1 reset page
    '{1'b0,1'b0,4'h0,16'h8001,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h1, 8'd4},  // R4 read
    '{1'b0,1'b0,4'h0,16'h9FFF,1'b0,1'b1, 1'b0,1'b1,1'b1, 4'h0,3'h1, 8'd4},  // R4 write
    '{1'b0,1'b0,4'h0,16'hC000,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h0, 8'd5},  // R5 read
    '{1'b0,1'b0,4'h0,16'hFFFF,1'b0,1'b1, 1'b0,1'b1,1'b1, 4'h0,3'h0, 8'd5},  // R5 write
    '{1'b0,1'b0,4'h0,16'h0100,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd6},  // R6 window 0
    '{1'b0,1'b0,4'h0,16'h7FFF,1'b0,1'b1, 1'b0,1'b0,1'b0, 4'h1,3'h0, 8'd6},  // R6 window 1
    '{1'b1,1'b0,4'h5,16'h4000,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'h1,3'h0, 8'd7},  // R7 old page same cycle
    '{1'b0,1'b0,4'h0,16'h4000,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'h5,3'h0, 8'd7},  // R7 new page
    '{1'b1,1'b1,4'h6,16'h8000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h1, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'hBFFF,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h6, 8'd7},  // R7 RAM page
    '{1'b1,1'b0,4'h0,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'h5555,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'h5,3'h0, 8'd8},  // R8 zero ignored
    '{1'b1,1'b1,4'h8,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'hA000,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h6, 8'd9},  // R9 eight ignored
    '{1'b1,1'b1,4'h0,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'h8888,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h6, 8'd9},  // R9 zero ignored
    '{1'b1,1'b0,4'hF,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'h6000,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'hF,3'h0, 8'd3},  // R3 top page
    '{1'b1,1'b1,4'h7,16'hA000,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h6, 8'd7},  // R7 old RAM page
    '{1'b0,1'b0,4'h0,16'hA000,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h7, 8'd7},  // R7 new RAM page
    '{1'b0,1'b0,4'h0,16'h8010,1'b1,1'b1, 1'b0,1'b1,1'b1, 4'h0,3'h7, 8'd11}, // R11 RAM
    '{1'b0,1'b0,4'h0,16'h4010,1'b1,1'b1, 1'b0,1'b0,1'b0, 4'hF,3'h0, 8'd11}, // R11 ROM
    '{1'b0,1'b0,4'h0,16'hC123,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b1,1'b1,4'h3,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0, 4'h0,3'h0, 8'd10}, // R10 idle
    '{1'b0,1'b0,4'h0,16'h4000,1'b1,1'b0, 1'b1,1'b0,1'b0, 4'hF,3'h0, 8'd7},  // R7 ROM untouched
    '{1'b0,1'b0,4'h0,16'h8000,1'b1,1'b0, 1'b0,1'b1,1'b0, 4'h0,3'h3, 8'd7}   // R7 RAM loaded
  };

  task automatic drive(input logic pw, input logic ps, input logic [3:0] pd,
                       input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk);
    pg_wr = pw; pg_sel = ps; pg_data = pd;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
  endtask

  task automatic check(input int req, input logic [15:0] a,
                       input logic xr, input logic xm, input logic xw,
                       input logic [3:0] rpg, input logic [2:0] mpg);
    logic [37:0] act, exp;
    act = {rom_cs, ram_cs, ram_we, rom_addr, ram_addr};
    exp = {xr, xm, xw, rpg, a[13:0], mpg, a[13:0]};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d addr=%h actual cs=%b%b we=%b rom=%h ram=%h expected cs=%b%b we=%b rom=%h ram=%h",
               req, a, rom_cs, ram_cs, ram_we, rom_addr, ram_addr,
               xr, xm, xw, {rpg, a[13:0]}, {mpg, a[13:0]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: outputs cleared while reset is held
    drive(1'b0, 1'b0, 4'h0, 16'h4321, 1'b1, 1'b0);
    @(posedge clk); #1;
    check(1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 3'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pw, VECS[i].ps, VECS[i].pd, VECS[i].a, VECS[i].rd, VECS[i].wr);
      @(posedge clk); #1;
      check(int'(VECS[i].req), VECS[i].a, VECS[i].x_rom, VECS[i].x_ram, VECS[i].x_we,
            VECS[i].x_rpg, VECS[i].x_mpg);
    end

    // R1: reset mid-run restores page 1 in both registers
    drive(1'b0, 1'b0, 4'h0, 16'h8000, 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk); #1;
    check(1, 16'h0000, 1'b0, 1'b0, 1'b0, 4'h0, 3'h0);
    drive(1'b0, 1'b0, 4'h0, 16'h7ABC, 1'b1, 1'b0);
    rst = 1'b0;
    @(posedge clk); #1;
    check(1, 16'h7ABC, 1'b1, 1'b0, 1'b0, 4'h1, 3'h0);
    drive(1'b0, 1'b0, 4'h0, 16'hBCDE, 1'b0, 1'b1);
    @(posedge clk); #1;
    check(1, 16'hBCDE, 1'b0, 1'b1, 1'b1, 4'h0, 3'h1);

    // R3: lowest legal page after a write of 1
    drive(1'b1, 1'b0, 4'h1, 16'h0000, 1'b0, 1'b0);
    @(posedge clk); #1;
    drive(1'b0, 1'b0, 4'h0, 16'h4FFF, 1'b1, 1'b0);
    @(posedge clk); #1;
    check(3, 16'h4FFF, 1'b1, 1'b0, 1'b0, 4'h1, 3'h0);

    drive(1'b0, 1'b0, 4'h0, 16'h0000, 1'b0, 1'b0);
    @(posedge clk); #1;
    finish_run();
  end

endmodule